// File: doc/BRIEF.md
# Serial Frame Engine with Error-Tagged Receive Queue

This block is the bit-level core of an asynchronous serial port. A seven-bit frame-control word sets the character size (5 to 8 data bits), the parity mode (none, odd or even), one or two stop bits, whether the two character queues are 16 deep or a single holding register, and a forced-break state of the transmit line. Transmit characters go in through a push strobe and are sent LSB first, framed by a low start bit and high stop bits. Incoming characters are sampled on a 16x oversampling tick, decoded, and queued together with their own error flags.

Reads of the receive port return a 12-bit word: the character and the four flags that belong to it. Software sees queue status flags, a transmitter busy flag, and a receive-timeout flag that asks for service when a few characters sit in the queue and the line has gone quiet. Bus decoding and bit-rate generation are outside the block; it is given a tick that pulses 16 times per bit period.

Top module: `uart_fe_top`

## Requirements
- R1: Frame-control bits 6:5 set the data length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits); the transmitter sends a 0 start bit, the data LSB first, and high stop bits, each bit lasting 16 ticks.
- R2: Frame-control bit 1 adds a parity bit after the data; bit 2 makes it even (data ones plus parity bit even) when set, odd when clear. A received character whose parity bit disagrees gets bit 9 of its word set.
- R3: Frame-control bit 3 selects two stop bits instead of one, lengthening each transmitted frame by one bit period.
- R4: While frame-control bit 0 is set, the transmit line is held low.
- R5: A received word holds the data in bits 7:0 (zero above the data length) and sets bit 8 when any expected stop bit is sampled low.
- R6: A frame during which every sample (start, data, parity, stop) is low is stored as 0x800: data zero, only bit 11 set. The receiver then waits for the line to go high before looking for a new start bit.
- R7: Frame-control bit 4 set gives each direction a 16-entry queue; clear gives a single entry. The full flag shows the queue at its capacity.
- R8: A character that completes while the receive queue is full is discarded, and bit 10 is set on the newest entry already stored.
- R9: The timeout flag rises when the receive queue is non-empty and no character has completed for 32 bit periods (512 ticks); a read clears it.
- R10: A pop on an empty receive queue and a push on a full transmit queue have no effect; queued characters come out in arrival order.
- R11: The busy flag is high from the moment a character is taken for sending until its last stop bit period ends; a start bit is accepted only if the line is still low at mid-bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit period |
| fcon_i | input | 7 | Frame-control word |
| tx_push_i | input | 1 | Push strobe for transmit data |
| tx_data_i | input | 8 | Transmit character |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_busy_o | output | 1 | Transmitter sending a frame |
| tx_line_o | output | 1 | Serial output line |
| rx_line_i | input | 1 | Serial input line |
| rx_pop_i | input | 1 | Pop strobe for receive data |
| rx_word_o | output | 12 | Head of receive queue: flags and data |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_timeout_o | output | 1 | Receive timeout pending |

## Verification
The assertions watch, on every cycle, that neither queue holds more than its current capacity, that an overrun mark only lands on a full queue, that a pop on an empty queue leaves its level unchanged, that the timeout flag never stands over an empty queue and drops after a read, and that the transmitter only starts when data is waiting. The correctness of the bit stream itself, the parity and stop encoding for each setting, break and framing detection, overrun tagging of the right entry, and the timeout delay can only be shown by the bench scenarios, which drive and decode frames from an independent model.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int OVS       = 16;
    localparam int FRAME_MAX = 12;

    typedef struct packed {
        logic [1:0] wlen;
        logic       fifo_en;
        logic       stop2;
        logic       even;
        logic       par_en;
        logic       brk;
    } fcon_t;

    typedef struct packed {
        logic       brk;
        logic       ovr;
        logic       pe;
        logic       fe;
        logic [7:0] data;
    } rx_word_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_state_t;

    function automatic logic [3:0] data_len(fcon_t c);
        return 4'd5 + {2'b00, c.wlen};
    endfunction

    function automatic logic [3:0] frame_len(fcon_t c);
        return data_len(c) + 4'd2 + {3'b000, c.par_en} + {3'b000, c.stop2};
    endfunction

    function automatic logic [7:0] trim(logic [7:0] d, fcon_t c);
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < 8; i++)
            if (4'(i) < data_len(c)) r[3'(i)] = d[3'(i)];
        return r;
    endfunction

    function automatic logic par_bit(logic [7:0] d, fcon_t c);
        return c.even ? (^trim(d, c)) : ~(^trim(d, c));
    endfunction

    function automatic logic [FRAME_MAX-1:0] build_frame(fcon_t c, logic [7:0] d);
        logic [FRAME_MAX-1:0] f;
        logic [3:0] n;
        f = '1;
        n = data_len(c);
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++)
            if (4'(i) < n) f[4'(i) + 4'd1] = d[3'(i)];
        if (c.par_en) f[n + 4'd1] = par_bit(d, c);
        return f;
    endfunction

    function automatic rx_word_t decode_frame(logic [FRAME_MAX-1:0] s, fcon_t c);
        rx_word_t   w;
        logic [3:0] n, nb, sp;
        logic [7:0] d;
        logic       allz;
        n    = data_len(c);
        nb   = frame_len(c);
        d    = '0;
        allz = 1'b1;
        for (int i = 0; i < 8; i++)
            if (4'(i) < n) d[3'(i)] = s[4'(i) + 4'd1];
        for (int i = 0; i < FRAME_MAX; i++)
            if (4'(i) < nb && s[4'(i)]) allz = 1'b0;
        sp     = n + 4'd1 + {3'b000, c.par_en};
        w      = '0;
        w.data = d;
        w.pe   = c.par_en && (s[n + 4'd1] != par_bit(d, c));
        w.fe   = !s[sp] || (c.stop2 && !s[sp + 4'd1]);
        if (allz) begin
            w     = '0;
            w.brk = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/uart_fe_fifo.sv
module uart_fe_fifo #(
    parameter int W        = 12,
    parameter int DEPTH    = 16,
    parameter int MARK_BIT = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         deep_i,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    input  logic         mark_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
    logic [CW-1:0] count, cap;
    logic          do_push, do_pop;

    assign cap      = deep_i ? CW'(DEPTH) : CW'(1);
    assign full_o   = (count >= cap);
    assign empty_o  = (count == '0);
    assign do_push  = push_i && !full_o;
    assign do_pop   = pop_i && !empty_o;
    assign last_ptr = wr_ptr - AW'(1);
    assign rdata_o  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
        if (mark_i && !empty_o) mem[last_ptr][MARK_BIT] <= 1'b1;
    end

    a_r7_within_cap: assert property (@(posedge clk) disable iff (rst)
        count <= cap);
    a_r10_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o && !push_i) |=> $stable(count));
    a_r8_mark_full: assert property (@(posedge clk) disable iff (rst)
        mark_i |-> full_o);
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
    import uart_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  fcon_t      cfg_i,
    input  logic       have_i,
    input  logic [7:0] data_i,
    output logic       take_o,
    output logic       line_o,
    output logic       busy_o
);
    localparam int CNTW = $clog2(OVS);

    logic [FRAME_MAX-1:0] frame;
    logic [3:0]           nbits, bit_idx;
    logic [CNTW-1:0]      cnt;
    logic                 active;

    assign take_o = !active && have_i;
    assign busy_o = active;
    assign line_o = (active ? frame[bit_idx] : 1'b1) & ~cfg_i.brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            frame   <= '1;
            nbits   <= 4'd1;
            bit_idx <= '0;
            cnt     <= '0;
        end else if (take_o) begin
            active  <= 1'b1;
            frame   <= build_frame(cfg_i, data_i);
            nbits   <= frame_len(cfg_i);
            bit_idx <= '0;
            cnt     <= '0;
        end else if (active && tick_i) begin
            if (cnt == CNTW'(OVS - 1)) begin
                cnt <= '0;
                if (bit_idx == nbits - 4'd1) active  <= 1'b0;
                else                         bit_idx <= bit_idx + 4'd1;
            end else begin
                cnt <= cnt + CNTW'(1);
            end
        end
    end

    a_r11_start_needs_data: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(have_i));
    a_r3_index_in_frame: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (bit_idx < nbits));
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
    import uart_fe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  fcon_t    cfg_i,
    input  logic     line_i,
    output logic     done_o,
    output rx_word_t word_o
);
    localparam int CNTW = $clog2(OVS);

    rx_state_t            st;
    fcon_t                lcfg;
    logic [FRAME_MAX-1:0] samp;
    logic [3:0]           nbits, bit_idx;
    logic [CNTW-1:0]      cnt;
    logic                 s1, s2, fin;

    assign done_o = fin;
    assign word_o = decode_frame(samp, lcfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= line_i;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            lcfg    <= '0;
            samp    <= '1;
            nbits   <= 4'd1;
            bit_idx <= '0;
            cnt     <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (tick_i) begin
                case (st)
                    RX_IDLE: if (!s2) begin
                        st    <= RX_START;
                        cnt   <= CNTW'(1);
                        lcfg  <= cfg_i;
                        nbits <= frame_len(cfg_i);
                    end
                    RX_START: begin
                        if (cnt == CNTW'(OVS / 2 - 1)) begin
                            cnt <= '0;
                            if (!s2) begin
                                st      <= RX_BITS;
                                samp    <= '1;
                                samp[0] <= 1'b0;
                                bit_idx <= 4'd1;
                            end else begin
                                st <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + CNTW'(1);
                        end
                    end
                    RX_BITS: begin
                        if (cnt == CNTW'(OVS - 1)) begin
                            cnt           <= '0;
                            samp[bit_idx] <= s2;
                            if (bit_idx == nbits - 4'd1) begin
                                fin <= 1'b1;
                                st  <= s2 ? RX_IDLE : RX_HOLD;
                            end else begin
                                bit_idx <= bit_idx + 4'd1;
                            end
                        end else begin
                            cnt <= cnt + CNTW'(1);
                        end
                    end
                    default: if (s2) st <= RX_IDLE;
                endcase
            end
        end
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/uart_fe_top.sv
module uart_fe_top
    import uart_fe_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TO_BITS    = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic [6:0]  fcon_i,
    input  logic        tx_push_i,
    input  logic [7:0]  tx_data_i,
    output logic        tx_full_o,
    output logic        tx_empty_o,
    output logic        tx_busy_o,
    output logic        tx_line_o,
    input  logic        rx_line_i,
    input  logic        rx_pop_i,
    output logic [11:0] rx_word_o,
    output logic        rx_empty_o,
    output logic        rx_full_o,
    output logic        rx_timeout_o
);
    localparam int TO_LIMIT = TO_BITS * OVS;
    localparam int TOW      = $clog2(TO_LIMIT + 1);

    fcon_t      cfg;
    logic [7:0] txq_data;
    logic       tx_take, rx_done;
    rx_word_t   rx_new;
    logic [TOW-1:0] to_cnt;

    assign cfg = fcon_t'(fcon_i);

    uart_fe_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .MARK_BIT(0)) u_txq (
        .clk(clk), .rst(rst), .deep_i(cfg.fifo_en),
        .push_i(tx_push_i), .wdata_i(tx_data_i), .pop_i(tx_take), .mark_i(1'b0),
        .rdata_o(txq_data), .empty_o(tx_empty_o), .full_o(tx_full_o));

    uart_fe_tx u_tx (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cfg_i(cfg),
        .have_i(!tx_empty_o), .data_i(txq_data), .take_o(tx_take),
        .line_o(tx_line_o), .busy_o(tx_busy_o));

    uart_fe_rx u_rx (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cfg_i(cfg),
        .line_i(rx_line_i), .done_o(rx_done), .word_o(rx_new));

    uart_fe_fifo #(.W(12), .DEPTH(FIFO_DEPTH), .MARK_BIT(10)) u_rxq (
        .clk(clk), .rst(rst), .deep_i(cfg.fifo_en),
        .push_i(rx_done), .wdata_i(rx_new), .pop_i(rx_pop_i),
        .mark_i(rx_done && rx_full_o),
        .rdata_o(rx_word_o), .empty_o(rx_empty_o), .full_o(rx_full_o));

    always_ff @(posedge clk) begin
        if (rst || rx_done || rx_empty_o || rx_pop_i)
            to_cnt <= '0;
        else if (tick_i && to_cnt != TOW'(TO_LIMIT))
            to_cnt <= to_cnt + TOW'(1);
    end

    assign rx_timeout_o = (to_cnt == TOW'(TO_LIMIT));

    a_r9_timeout_nonempty: assert property (@(posedge clk) disable iff (rst)
        rx_timeout_o |-> !rx_empty_o);
    a_r9_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (rx_pop_i && !rx_empty_o) |=> !rx_timeout_o);
endmodule

// File: tb/uart_fe_top_tb.sv
module uart_fe_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic [6:0]  fcon_i = 7'h70;
    logic        tx_push_i = 1'b0;
    logic [7:0]  tx_data_i = 8'h00;
    logic        tx_full_o, tx_empty_o, tx_busy_o, tx_line_o;
    logic        rx_line_i = 1'b1;
    logic        rx_pop_i = 1'b0;
    logic [11:0] rx_word_o;
    logic        rx_empty_o, rx_full_o, rx_timeout_o;

    int checks = 0;
    int errors = 0;
    bit live = 0;
    bit wd = 0;

    localparam int BITCYC = 32;

    uart_fe_top u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .fcon_i(fcon_i),
        .tx_push_i(tx_push_i), .tx_data_i(tx_data_i),
        .tx_full_o(tx_full_o), .tx_empty_o(tx_empty_o), .tx_busy_o(tx_busy_o),
        .tx_line_o(tx_line_o), .rx_line_i(rx_line_i), .rx_pop_i(rx_pop_i),
        .rx_word_o(rx_word_o), .rx_empty_o(rx_empty_o), .rx_full_o(rx_full_o),
        .rx_timeout_o(rx_timeout_o));

    always #4 clk = ~clk;

    always @(posedge clk) tick_i <= rst ? 1'b0 : ~tick_i;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // per-clock consistency of the flag model (R10)
    always @(negedge clk) begin
        if (live) begin
            if (tx_full_o)    check("R10 tx full implies not empty", tx_empty_o, 0);
            if (rx_full_o)    check("R10 rx full implies not empty", rx_empty_o, 0);
            if (rx_timeout_o) check("R9 timeout implies not empty", rx_empty_o, 0);
        end
    end

    function automatic logic [6:0] fc(int wl, bit fifo, bit st2, bit ev, bit pen, bit brk);
        return {2'(wl), fifo, st2, ev, pen, brk};
    endfunction

    function automatic int nbits_of(int nd, bit pen, bit st2);
        return nd + 2 + int'(pen) + int'(st2);
    endfunction

    function automatic logic [11:0] mk_bits(int d, int nd, bit pen, bit ev, bit st2);
        logic [11:0] b;
        int ones;
        b = '1;
        b[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            b[1+i] = d[i];
            ones += d[i];
        end
        if (pen) b[1+nd] = ev ? ((ones % 2) == 1) : ((ones % 2) == 0);
        return b;
    endfunction

    task automatic send_rx(input logic [11:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            rx_line_i = b[i];
            repeat (BITCYC) @(negedge clk);
        end
        rx_line_i = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_rx(input string tag, input int exp);
        @(negedge clk);
        check({tag, " not empty"}, rx_empty_o, 0);
        check(tag, rx_word_o, exp);
        rx_pop_i = 1'b1;
        @(negedge clk);
        rx_pop_i = 1'b0;
    endtask

    task automatic push_tx(input int d);
        @(negedge clk);
        tx_data_i = 8'(d);
        tx_push_i = 1'b1;
        @(negedge clk);
        tx_push_i = 1'b0;
    endtask

    task automatic capture_tx(output logic [11:0] b, input int nb);
        b = '1;
        while (tx_line_o !== 1'b0) @(negedge clk);
        repeat (BITCYC / 2) @(negedge clk);
        b[0] = tx_line_o;
        for (int i = 1; i < nb; i++) begin
            repeat (BITCYC) @(negedge clk);
            b[i] = tx_line_o;
        end
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!tx_busy_o) @(negedge clk);
        while (tx_busy_o) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic main_seq();
        logic [11:0] got, ex;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset tx_line", tx_line_o, 1);
        check("reset tx_empty", tx_empty_o, 1);
        check("reset tx_busy", tx_busy_o, 0);
        check("reset rx_empty", rx_empty_o, 1);
        check("reset rx_timeout", rx_timeout_o, 0);
        check("reset tx_full", tx_full_o, 0);
        live = 1;

        // R1: 8N1 transmit
        fcon_i = fc(3, 1, 0, 0, 0, 0);
        push_tx(8'hA5);
        capture_tx(got, 10);
        check("R1 tx 8N1 frame", int'(got[9:0]), int'(mk_bits(8'hA5, 8, 0, 0, 0) & 12'h3FF));
        repeat (40) @(negedge clk);

        // R1: 5-bit, no parity
        fcon_i = fc(0, 1, 0, 0, 0, 0);
        push_tx(8'hF3);
        capture_tx(got, 7);
        check("R1 tx 5N1 frame", int'(got[6:0]), int'(mk_bits(8'h13, 5, 0, 0, 0) & 12'h7F));
        repeat (40) @(negedge clk);

        // R2: 7-bit even and odd parity
        fcon_i = fc(2, 1, 0, 1, 1, 0);
        push_tx(8'h35);
        capture_tx(got, 10);
        check("R2 tx 7E1 frame", int'(got[9:0]), int'(mk_bits(8'h35, 7, 1, 1, 0) & 12'h3FF));
        repeat (40) @(negedge clk);
        fcon_i = fc(2, 1, 0, 0, 1, 0);
        push_tx(8'h35);
        capture_tx(got, 10);
        check("R2 tx 7O1 frame", int'(got[9:0]), int'(mk_bits(8'h35, 7, 1, 0, 0) & 12'h3FF));
        repeat (40) @(negedge clk);

        // R3 / R11: busy length for one and two stop bits
        fcon_i = fc(3, 1, 0, 0, 0, 0);
        push_tx(8'h0F);
        busy_len(n);
        check("R11 busy length 8N1", int'(n >= 10*BITCYC-3 && n <= 10*BITCYC+3), 1);
        fcon_i = fc(3, 1, 1, 0, 0, 0);
        push_tx(8'h0F);
        busy_len(n);
        check("R3 busy length 8N2", int'(n >= 11*BITCYC-3 && n <= 11*BITCYC+3), 1);
        repeat (10) @(negedge clk);

        // R4: forced break
        fcon_i = fc(3, 1, 0, 0, 0, 1);
        repeat (3) @(negedge clk);
        check("R4 break holds line low", tx_line_o, 0);
        repeat (50) @(negedge clk);
        check("R4 break still low", tx_line_o, 0);
        fcon_i = fc(3, 1, 0, 0, 0, 0);
        @(negedge clk);
        check("R4 line high after break", tx_line_o, 1);

        // R5: 8N1 receive, 6-bit receive
        send_rx(mk_bits(8'h5A, 8, 0, 0, 0), 10);
        read_rx("R5 rx 8N1 word", 12'h05A);
        fcon_i = fc(1, 1, 0, 0, 0, 0);
        send_rx(mk_bits(8'h2D, 6, 0, 0, 0), 8);
        read_rx("R5 rx 6N1 word", 12'h02D);

        // R2: parity ok and bad
        fcon_i = fc(2, 1, 0, 0, 1, 0);
        send_rx(mk_bits(8'h35, 7, 1, 0, 0), 10);
        read_rx("R2 rx 7O1 good parity", 12'h035);
        ex = mk_bits(8'h35, 7, 1, 0, 0);
        ex[8] = ~ex[8];
        send_rx(ex, 10);
        read_rx("R2 rx 7O1 parity error", 12'h235);

        // R5: framing error
        fcon_i = fc(3, 1, 0, 0, 0, 0);
        ex = mk_bits(8'h3C, 8, 0, 0, 0);
        ex[9] = 1'b0;
        send_rx(ex, 10);
        repeat (BITCYC) @(negedge clk);
        read_rx("R5 rx framing error", 12'h13C);

        // R6: break, then a normal frame after the line recovers
        send_rx(12'h000, 11);
        repeat (BITCYC) @(negedge clk);
        read_rx("R6 rx break word", 12'h800);
        check("R6 single entry for break", rx_empty_o, 1);
        send_rx(mk_bits(8'hC3, 8, 0, 0, 0), 10);
        read_rx("R6 rx after break", 12'h0C3);

        // R10: pop on empty queue
        rx_pop_i = 1'b1;
        @(negedge clk);
        rx_pop_i = 1'b0;
        @(negedge clk);
        check("R10 pop empty stays empty", rx_empty_o, 1);
        send_rx(mk_bits(8'h66, 8, 0, 0, 0), 10);
        read_rx("R10 word after empty pop", 12'h066);
        check("R10 empty after one read", rx_empty_o, 1);

        // R7 / R8: single holding register
        fcon_i = fc(3, 0, 0, 0, 0, 0);
        send_rx(mk_bits(8'h11, 8, 0, 0, 0), 10);
        check("R7 single entry full", rx_full_o, 1);
        send_rx(mk_bits(8'h22, 8, 0, 0, 0), 10);
        read_rx("R8 overrun on holding reg", 12'h411);
        check("R8 arriving char discarded", rx_empty_o, 1);

        // R7 / R8: 16-entry queue
        fcon_i = fc(3, 1, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) send_rx(mk_bits(8'h40 + i, 8, 0, 0, 0), 10);
        check("R7 queue full at 16", rx_full_o, 1);
        send_rx(mk_bits(8'h7E, 8, 0, 0, 0), 10);
        for (int i = 0; i < 15; i++) read_rx("R10 queue order", 12'h040 + i);
        read_rx("R8 overrun on newest entry", 12'h44F);
        check("R8 17th char discarded", rx_empty_o, 1);

        // R9: timeout
        send_rx(mk_bits(8'h77, 8, 0, 0, 0), 10);
        repeat (900) @(negedge clk);
        check("R9 no timeout before 32 bits", rx_timeout_o, 0);
        repeat (200) @(negedge clk);
        check("R9 timeout after 32 bits", rx_timeout_o, 1);
        read_rx("R9 word under timeout", 12'h077);
        check("R9 timeout cleared by read", rx_timeout_o, 0);

        // R10 / R7: transmit burst, 18 pushes into 1 shifter + 16 entries
        fork
            begin
                for (int i = 0; i < 18; i++) begin
                    @(negedge clk);
                    tx_data_i = 8'h80 + 8'(i);
                    tx_push_i = 1'b1;
                end
                @(negedge clk);
                tx_push_i = 1'b0;
                check("R7 tx queue full", tx_full_o, 1);
            end
            begin
                for (int i = 0; i < 17; i++) begin
                    capture_tx(got, 10);
                    check("R10 tx burst order", int'(got[9:0]),
                          int'(mk_bits(8'h80 + i, 8, 0, 0, 0) & 12'h3FF));
                end
            end
        join
        repeat (100) @(negedge clk);
        check("R10 push on full ignored (idle)", tx_busy_o, 0);
        check("R10 tx queue drained", tx_empty_o, 1);
        check("R10 line idle high", tx_line_o, 1);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (190000) @(posedge clk);
                wd = 1;
            end
        join_any
        live = 0;
        if (wd) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule